// File: doc/BRIEF.md
# Double-Buffered Parallel-to-Serial Converter

This block captures a parallel word into a holding stage and then converts it into a bit stream. A store enable samples the parallel input into the holding stage. A separate shift stage is filled from the holding stage and shifts its contents out one bit per shift enable. Because the two stages are separate, a new word can be captured while the previous one is still being shifted out.

Transfer into the shift stage is controlled by an active-low load level. Emptying it is controlled by an active-low clear level. Both are sampled on every rising edge of a single system clock. The store and shift requests are single-cycle clock enables.

Several converters can be chained by connecting one serial output to the next serial input. The clear-plus-load combination is illegal, and its shift-stage result must not be relied on. The logic resolves it deterministically by letting clear win.

Top module: `piso_dbuf`

## Requirements
- R1: While `rst` is high, both stages go to zero. `ser_out` is 0 on the first cycle after reset.
- R2: When `store_en` is high at a clock edge, the holding stage takes `par_in`, whatever the levels of `load_n`, `clear_n` and `shift_en`. Otherwise the holding stage keeps its value.
- R3: When `load_n` is 0 and `clear_n` is 1 at an edge without `store_en`, the shift stage takes the holding-stage value. A `shift_en` in that cycle has no effect.
- R4: When `store_en` is high and `load_n` is 0 with `clear_n` at 1, the shift stage takes `par_in` at that same edge.
- R5: When `clear_n` is 0 at an edge, the shift stage becomes all zeros. The holding stage is not changed by the clear.
- R6: When `shift_en` is high and both `load_n` and `clear_n` are 1, every bit n of the shift stage takes the old bit n-1, and bit 0 takes `ser_in`.
- R7: When none of load, clear or shift is active, the shift stage holds its value.
- R8: `ser_out` is always the most significant bit (bit WIDTH-1) of the shift stage. After a load, WIDTH shifts present the stored word most significant bit first. A bit presented on `ser_in` reaches `ser_out` after WIDTH shifts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| store_en | input | 1 | One-cycle request to capture `par_in` into the holding stage |
| par_in | input | WIDTH | Parallel data word |
| load_n | input | 1 | Active-low level: copy the holding stage into the shift stage |
| clear_n | input | 1 | Active-low level: zero the shift stage |
| shift_en | input | 1 | One-cycle request to shift toward the serial output |
| ser_in | input | 1 | Serial data entering at bit 0 |
| ser_out | output | 1 | Serial data, the top bit of the shift stage |

## Verification
Every control acts at the rising edge where it is sampled, and `ser_out` comes straight from a flop. So the effect of inputs driven before edge k is visible on `ser_out` from edge k on. The bench drives inputs on the falling edge, lets one rising edge pass, and compares `ser_out` against its reference model on the next falling edge. Contents of the shift stage that `ser_out` does not show directly are brought out by following a stimulus with WIDTH shifts and comparing each bit in turn. The same holds for what the holding stage kept across a clear: a load brings it into the shift stage, and the shifts then bring it out.

// File: rtl/piso_dbuf_pkg.sv
package piso_dbuf_pkg;

    // Operation applied to the shift stage at the next edge, in priority order
    typedef enum logic [1:0] {
        SOP_HOLD  = 2'd0,
        SOP_SHIFT = 2'd1,
        SOP_LOAD  = 2'd2,
        SOP_CLEAR = 2'd3
    } shop_e;

    // Control word handed from the decoder to the shift stage
    typedef struct packed {
        shop_e op;
        logic  take_new;   // load source is the live parallel input
    } shctl_t;

    // Clear wins over load; load wins over shift
    function automatic shop_e pick_op(input logic load_n,
                                      input logic clear_n,
                                      input logic shift_en);
        shop_e r;
        if (!clear_n)      r = SOP_CLEAR;
        else if (!load_n)  r = SOP_LOAD;
        else if (shift_en) r = SOP_SHIFT;
        else               r = SOP_HOLD;
        return r;
    endfunction

endpackage

// File: rtl/piso_dbuf_ctrl.sv
module piso_dbuf_ctrl
    import piso_dbuf_pkg::*;
(
    input  logic   load_n,
    input  logic   clear_n,
    input  logic   shift_en,
    input  logic   store_en,
    output shctl_t ctl
);
    always_comb begin
        ctl.op       = pick_op(load_n, clear_n, shift_en);
        ctl.take_new = (ctl.op == SOP_LOAD) && store_en;
    end
endmodule

// File: rtl/piso_dbuf_store.sv
module piso_dbuf_store #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             store_en,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] stage_q
);
    always_ff @(posedge clk) begin
        if (rst)           stage_q <= '0;
        else if (store_en) stage_q <= par_in;
    end
endmodule

// File: rtl/piso_dbuf_shift.sv
module piso_dbuf_shift
    import piso_dbuf_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  shctl_t           ctl,
    input  logic [WIDTH-1:0] stage_q,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_in,
    output logic [WIDTH-1:0] shift_q
);
    logic [WIDTH-1:0] load_src;
    logic [WIDTH-1:0] lower;
    logic [WIDTH-1:0] shift_d;

    // Pass-through: a store in the same cycle as a load feeds the new word
    assign load_src = ctl.take_new ? par_in : stage_q;

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        if (g == 0) begin : g_entry
            assign lower[g] = ser_in;
        end else begin : g_chain
            assign lower[g] = shift_q[g-1];
        end

        always_comb begin
            unique case (ctl.op)
                SOP_CLEAR: shift_d[g] = 1'b0;
                SOP_LOAD:  shift_d[g] = load_src[g];
                SOP_SHIFT: shift_d[g] = lower[g];
                default:   shift_d[g] = shift_q[g];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) shift_q <= '0;
        else     shift_q <= shift_d;
    end
endmodule

// File: rtl/piso_dbuf.sv
module piso_dbuf
    import piso_dbuf_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             store_en,
    input  logic [WIDTH-1:0] par_in,
    input  logic             load_n,
    input  logic             clear_n,
    input  logic             shift_en,
    input  logic             ser_in,
    output logic             ser_out
);
    localparam int TOP = WIDTH - 1;

    shctl_t           ctl;
    logic [WIDTH-1:0] stage_q;
    logic [WIDTH-1:0] shift_q;

    piso_dbuf_ctrl u_ctrl (
        .load_n   (load_n),
        .clear_n  (clear_n),
        .shift_en (shift_en),
        .store_en (store_en),
        .ctl      (ctl)
    );

    piso_dbuf_store #(.WIDTH(WIDTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .store_en (store_en),
        .par_in   (par_in),
        .stage_q  (stage_q)
    );

    piso_dbuf_shift #(.WIDTH(WIDTH)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .stage_q  (stage_q),
        .par_in   (par_in),
        .ser_in   (ser_in),
        .shift_q  (shift_q)
    );

    assign ser_out = shift_q[TOP];
endmodule

// File: rtl/piso_dbuf_chk.sv
module piso_dbuf_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             store_en,
    input logic [WIDTH-1:0] par_in,
    input logic             load_n,
    input logic             clear_n,
    input logic             shift_en,
    input logic             ser_in,
    input logic             ser_out,
    input logic [WIDTH-1:0] stage_q,
    input logic [WIDTH-1:0] shift_q
);
    // R1
    a_r1_reset_zero: assert property (@(posedge clk)
        rst |=> (stage_q == '0) && (shift_q == '0));

    // R2
    a_r2_store_capture: assert property (@(posedge clk) disable iff (rst)
        store_en |=> stage_q == $past(par_in));

    // R2
    a_r2_store_keep: assert property (@(posedge clk) disable iff (rst)
        !store_en |=> $stable(stage_q));

    // R3
    a_r3_load_copy: assert property (@(posedge clk) disable iff (rst)
        (clear_n && !load_n && !store_en) |=> shift_q == $past(stage_q));

    // R4
    a_r4_load_passthru: assert property (@(posedge clk) disable iff (rst)
        (clear_n && !load_n && store_en) |=> shift_q == $past(par_in));

    // R5
    a_r5_clear_zero: assert property (@(posedge clk) disable iff (rst)
        !clear_n |=> shift_q == '0);

    // R6
    a_r6_shift_step: assert property (@(posedge clk) disable iff (rst)
        (clear_n && load_n && shift_en) |=>
            shift_q == {$past(shift_q[WIDTH-2:0]), $past(ser_in)});

    // R7
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (clear_n && load_n && !shift_en) |=> $stable(shift_q));

    // R8
    a_r8_out_follows: assert property (@(posedge clk) disable iff (rst)
        (clear_n && load_n && shift_en) |=> ser_out == $past(shift_q[WIDTH-2]));
endmodule

bind piso_dbuf piso_dbuf_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .store_en (store_en),
    .par_in   (par_in),
    .load_n   (load_n),
    .clear_n  (clear_n),
    .shift_en (shift_en),
    .ser_in   (ser_in),
    .ser_out  (ser_out),
    .stage_q  (stage_q),
    .shift_q  (shift_q)
);

// File: tb/sim_piso_dbuf.sv
`timescale 1ns/100ps
module sim_piso_dbuf;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         store_en = 1'b0;
    logic [W-1:0] par_in = '0;
    logic         load_n = 1'b1;
    logic         clear_n = 1'b1;
    logic         shift_en = 1'b0;
    logic         ser_in = 1'b0;
    logic         ser_out;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    logic [W-1:0] m_stage = '0;
    logic [W-1:0] m_shift = '0;

    always #2.5 clk = ~clk;

    piso_dbuf #(.WIDTH(W)) u0 (
        .clk(clk), .rst(rst), .store_en(store_en), .par_in(par_in),
        .load_n(load_n), .clear_n(clear_n), .shift_en(shift_en),
        .ser_in(ser_in), .ser_out(ser_out)
    );

    function automatic logic [W-1:0] next_shift(input logic [W-1:0] sh,
            input logic [W-1:0] stg, input logic st, input logic [W-1:0] d,
            input logic ld_n, input logic cl_n, input logic sf, input logic si);
        if (!cl_n)     return '0;
        else if (!ld_n) return st ? d : stg;
        else if (sf)   return {sh[W-2:0], si};
        return sh;
    endfunction

    task automatic check(input logic act, input logic exp, input string req);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: ser_out=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge after one rising edge
    task automatic cyc(input logic st, input logic [W-1:0] d, input logic ld_n,
                       input logic cl_n, input logic sf, input logic si, input string req);
        store_en = st; par_in = d; load_n = ld_n; clear_n = cl_n;
        shift_en = sf; ser_in = si;
        @(posedge clk);
        m_shift = next_shift(m_shift, m_stage, st, d, ld_n, cl_n, sf, si);
        if (st) m_stage = d;
        @(negedge clk);
        check(ser_out, m_shift[W-1], req);
    endtask

    // Shift out W bits and compare each against an independently stated word
    task automatic drain(input logic [W-1:0] want, input string req);
        for (int i = 0; i < W; i++) begin
            n_vec++;
            if (ser_out !== want[W-1-i]) begin
                n_bad++;
                $display("FAIL %s: bit %0d ser_out=%0b expected %0b", req, i, ser_out, want[W-1-i]);
            end
            cyc(1'b0, '0, 1'b1, 1'b1, 1'b1, 1'b0, req);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            summary();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check(ser_out, 1'b0, "R1");
        // R1: load without store exposes the zero holding stage
        cyc(1'b0, 8'hFF, 1'b0, 1'b1, 1'b0, 1'b1, "R1");
        drain(8'h00, "R1");

        // R2 + R3: store then load; shift_en during load ignored
        cyc(1'b1, 8'hA5, 1'b1, 1'b1, 1'b0, 1'b0, "R2");
        cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, "R3");
        cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, "R3");
        drain(8'hA5, "R8");

        // R4: store while load held passes through at once
        cyc(1'b1, 8'h3C, 1'b0, 1'b1, 1'b0, 1'b0, "R4");
        drain(8'h3C, "R4");

        // R5: clear zeros shift stage, holding stage survives
        cyc(1'b1, 8'hC3, 1'b0, 1'b1, 1'b0, 1'b0, "R5");
        cyc(1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, "R5");
        drain(8'h00, "R5");
        cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, "R5");
        drain(8'hC3, "R5");

        // R2: store during clear and during shifting still captures
        cyc(1'b1, 8'h5A, 1'b1, 1'b0, 1'b0, 1'b0, "R2");
        cyc(1'b1, 8'h96, 1'b1, 1'b1, 1'b1, 1'b1, "R2");
        cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, "R2");
        drain(8'h96, "R2");

        // R7: idle cycles hold
        cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, "R7");
        repeat (4) cyc(1'b0, 8'h11, 1'b1, 1'b1, 1'b0, 1'b1, "R7");
        drain(8'h96, "R7");

        // R6 + R8: serial input emerges W shifts later
        for (int i = 0; i < W; i++)
            cyc(1'b0, '0, 1'b1, 1'b1, 1'b1, logic'((8'hB2 >> (W-1-i)) & 1), "R6");
        drain(8'hB2, "R6");

        // Illegal clear+load: only defined state after a later clear is checked
        cyc(1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
        cyc(1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b0, "R5");
        drain(8'h00, "R5");

        // Random mix, never clear and load together
        for (int k = 0; k < 1500; k++) begin
            int sel = int'($urandom % 10);
            logic ld = (sel == 0 || sel == 1);
            logic cl = (sel == 2) && !ld;
            cyc(logic'($urandom % 3 == 0), W'($urandom), !ld, !cl,
                logic'($urandom % 2), logic'($urandom % 2), "R6");
        end

        done = 1;
        summary();
    end
endmodule